// File: doc/BRIEF.md
# Interrupt Priority and Vector Selector

This block decides which interrupt source a small 8-bit-style core services next, and it tells the core where to find that source's service address. There are three kinds of source. Reset comes from an active-low pin or an internal request. A software-interrupt strobe arrives when the core fetches a software-interrupt instruction. The rest are a vector of maskable hardware requests. When the block picks a source, it emits a one-cycle take strobe and a command to set the core's interrupt mask bit. It then holds the high and low byte addresses of the chosen vector pair until the core reports that the entry sequence is done. Register stacking and the memory reads stay in the core.

The software interrupt does not look at the mask bit. Hardware requests that were pending and unmasked when the software-interrupt instruction was fetched go ahead of it. Requests that turn up after that fetch wait behind it. Reset uses the same vectoring path, throws away any held or pending work, and is taken as soon as its request goes away.

Top module: `irq_vector_arbiter`

## Requirements
- R1: In the cycle after a reset request is sampled low again, take_o pulses with vec_hi_o = 0x3FFE and vec_lo_o = 0x3FFF. A reset request is pin_rst_n low, int_rst high, or the block's own rst_n.
- R2: While a reset request is active, take_o stays 0, the vector outputs read 0 and ack_o is 0. A held selection, a pending software interrupt and the captured snapshot are all discarded.
- R3: A software-interrupt strobe with nothing ahead of it is taken in the second cycle after the strobe, whatever mask_i is. It gives vec_hi_o = 0x3FFC and vec_lo_o = 0x3FFD.
- R4: Hardware request i gives vec_hi_o = 0x3FFA - 2*i and vec_lo_o = vec_hi_o + 1. When several are eligible, the lowest index wins. It is taken in the cycle after it is sampled with the block idle.
- R5: While mask_i is 1, no hardware request is taken.
- R6: Sources are served in this order: reset, then unmasked hardware requests that were pending at the software-interrupt strobe (and are still asserted), then the software interrupt, then other hardware requests.
- R7: take_o is high for exactly one cycle per selection, and set_mask_o is high in that same cycle.
- R8: The vector outputs stay constant from take_o until the cycle in which done_i is sampled, and read 0 while idle. A new selection comes at the earliest one cycle after that.
- R9: ack_o[i] is 1 only in a cycle where done_i is 1 and hardware source i is held. Otherwise ack_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low; leaves a reset vectoring pending |
| pin_rst_n | input | 1 | External reset request, active low |
| int_rst | input | 1 | Internal reset request, active high |
| swi_fetch_i | input | 1 | One-cycle strobe: software-interrupt instruction fetched |
| hw_req_i | input | NUM_HW | Hardware interrupt requests, index 0 highest |
| mask_i | input | 1 | Current interrupt mask bit |
| done_i | input | 1 | Core finished the vector fetch of the held source |
| take_o | output | 1 | One-cycle strobe: interrupt taken |
| vec_hi_o | output | ADDR_W | Address of the vector high byte |
| vec_lo_o | output | ADDR_W | Address of the vector low byte |
| set_mask_o | output | 1 | Command to set the interrupt mask bit |
| ack_o | output | NUM_HW | Per-source hardware acknowledge |

## Verification
The assertions assume three things about the core. It raises swi_fetch_i only while the block is idle. It raises done_i only while a source is held. It gives mask_i the value that was sampled one cycle before a hardware take. The stimulus drives swi_fetch_i only on idle cycles and done_i only after a take has been observed. It changes mask_i only on idle cycles, so no take can depend on a mask edge that falls in the middle of a selection.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RST  = 2'd1,
        SRC_SWI  = 2'd2,
        SRC_HW   = 2'd3
    } src_e;
endpackage

// File: rtl/irqv_first.sv
module irqv_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen
    import irqv_pkg::*;
#(
    parameter int          IW      = 2,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] VEC_TOP = 16'h3FFE
) (
    input  src_e              src,
    input  logic [IW-1:0]     idx,
    output logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] lo
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(VEC_TOP);

    always_comb begin
        case (src)
            SRC_RST: hi = TOP;
            SRC_SWI: hi = TOP - ADDR_W'(2);
            SRC_HW:  hi = TOP - ADDR_W'(4) - (ADDR_W'(idx) << 1);
            default: hi = '0;
        endcase
        lo = (src == SRC_NONE) ? '0 : hi + ADDR_W'(1);
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irqv_pkg::*;
#(
    parameter int          NUM_HW  = 4,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] VEC_TOP = 16'h3FFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst_n,
    input  logic              int_rst,
    input  logic              swi_fetch_i,
    input  logic [NUM_HW-1:0] hw_req_i,
    input  logic              mask_i,
    input  logic              done_i,
    output logic              take_o,
    output logic [ADDR_W-1:0] vec_hi_o,
    output logic [ADDR_W-1:0] vec_lo_o,
    output logic              set_mask_o,
    output logic [NUM_HW-1:0] ack_o
);
    localparam int IW = (NUM_HW > 1) ? $clog2(NUM_HW) : 1;

    typedef struct packed {
        logic              busy;
        logic              take;
        logic              rst_pend;
        logic              swi_pend;
        logic [NUM_HW-1:0] snap;
        src_e              src;
        logic [IW-1:0]     idx;
    } st_t;

    localparam st_t ST_RST = '{busy: 1'b0, take: 1'b0, rst_pend: 1'b1,
                               swi_pend: 1'b0, snap: '0, src: SRC_NONE,
                               idx: '0};

    st_t st_d, st_q;

    logic              rst_req;
    logic              busy;
    logic [NUM_HW-1:0] snap_live;
    logic [NUM_HW-1:0] elig_snap;
    logic [NUM_HW-1:0] elig_new;
    logic              snap_hit, new_hit;
    logic [IW-1:0]     snap_idx, new_idx;

    assign rst_req   = ~pin_rst_n | int_rst;
    assign busy      = st_q.busy;
    assign snap_live = st_q.snap & hw_req_i;
    assign elig_snap = snap_live & {NUM_HW{~mask_i}};
    assign elig_new  = hw_req_i & {NUM_HW{~mask_i}};

    irqv_first #(.N(NUM_HW), .IW(IW)) u_first_snap (
        .req(elig_snap), .found(snap_hit), .idx(snap_idx)
    );

    irqv_first #(.N(NUM_HW), .IW(IW)) u_first_new (
        .req(elig_new), .found(new_hit), .idx(new_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.snap = swi_fetch_i ? elig_new : snap_live;
        if (swi_fetch_i) begin
            st_d.swi_pend = 1'b1;
        end

        if (rst_req) begin
            st_d.busy     = 1'b0;
            st_d.rst_pend = 1'b1;
            st_d.swi_pend = 1'b0;
            st_d.snap     = '0;
            st_d.src      = SRC_NONE;
            st_d.idx      = '0;
        end else if (st_q.busy) begin
            if (done_i) begin
                st_d.busy = 1'b0;
                st_d.src  = SRC_NONE;
                st_d.idx  = '0;
            end
        end else if (st_q.rst_pend) begin
            st_d.rst_pend = 1'b0;
            st_d.take     = 1'b1;
            st_d.busy     = 1'b1;
            st_d.src      = SRC_RST;
            st_d.idx      = '0;
        end else if (st_q.swi_pend && snap_hit) begin
            st_d.take           = 1'b1;
            st_d.busy           = 1'b1;
            st_d.src            = SRC_HW;
            st_d.idx            = snap_idx;
            st_d.snap[snap_idx] = 1'b0;
        end else if (st_q.swi_pend && (snap_live == '0)) begin
            st_d.swi_pend = 1'b0;
            st_d.take     = 1'b1;
            st_d.busy     = 1'b1;
            st_d.src      = SRC_SWI;
            st_d.idx      = '0;
        end else if (new_hit) begin
            st_d.take          = 1'b1;
            st_d.busy          = 1'b1;
            st_d.src           = SRC_HW;
            st_d.idx           = new_idx;
            st_d.snap[new_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    irqv_vecgen #(.IW(IW), .ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP)) u_vecgen (
        .src(st_q.src), .idx(st_q.idx), .hi(vec_hi_o), .lo(vec_lo_o)
    );

    assign take_o     = st_q.take;
    assign set_mask_o = st_q.take;

    always_comb begin
        for (int i = 0; i < NUM_HW; i++) begin
            ack_o[i] = st_q.busy && done_i && !rst_req &&
                       (st_q.src == SRC_HW) && (st_q.idx == IW'(i));
        end
    end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
    parameter int          NUM_HW  = 4,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] VEC_TOP = 16'h3FFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_rst_n,
    input logic              int_rst,
    input logic              mask_i,
    input logic              done_i,
    input logic              busy,
    input logic              take_o,
    input logic              set_mask_o,
    input logic [ADDR_W-1:0] vec_hi_o,
    input logic [ADDR_W-1:0] vec_lo_o,
    input logic [NUM_HW-1:0] ack_o
);
    localparam logic [ADDR_W-1:0] V_RST = ADDR_W'(VEC_TOP);
    localparam logic [ADDR_W-1:0] V_SWI = ADDR_W'(VEC_TOP) - ADDR_W'(2);

    logic rreq;
    assign rreq = ~pin_rst_n | int_rst;

    // R1
    reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rreq) && !rreq) |=> (take_o && vec_hi_o == V_RST));

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rreq |=> (!take_o && ack_o == '0));

    // R5
    mask_blocks_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_hi_o != V_RST && vec_hi_o != V_SWI) |-> !$past(mask_i));

    // R7
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R7
    set_mask_with_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> set_mask_o);

    // R8
    vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_i && !rreq) |=> ($stable(vec_hi_o) && $stable(vec_lo_o)));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R9
    ack_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> (done_i && busy));
endmodule

bind irq_vector_arbiter irqv_chk #(
    .NUM_HW(NUM_HW), .ADDR_W(ADDR_W), .VEC_TOP(VEC_TOP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .int_rst(int_rst),
    .mask_i(mask_i), .done_i(done_i), .busy(busy), .take_o(take_o),
    .set_mask_o(set_mask_o), .vec_hi_o(vec_hi_o), .vec_lo_o(vec_lo_o),
    .ack_o(ack_o)
);

// File: tb/irq_vector_arbiter_tb.sv
`timescale 1ns/1ps
module irq_vector_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_rst_n = 1'b1;
    logic        int_rst = 1'b0;
    logic        swi_fetch_i = 1'b0;
    logic [3:0]  hw_req_i = '0;
    logic        mask_i = 1'b0;
    logic        done_i = 1'b0;
    logic        take_o, set_mask_o;
    logic [15:0] vec_hi_o, vec_lo_o;
    logic [3:0]  ack_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irq_vector_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .int_rst(int_rst),
        .swi_fetch_i(swi_fetch_i), .hw_req_i(hw_req_i), .mask_i(mask_i),
        .done_i(done_i), .take_o(take_o), .vec_hi_o(vec_hi_o),
        .vec_lo_o(vec_lo_o), .set_mask_o(set_mask_o), .ack_o(ack_o)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_take(input string tag, input logic [15:0] hi);
        check({tag, " take"}, {31'd0, take_o}, 32'd1);
        check({tag, " setmask"}, {31'd0, set_mask_o}, 32'd1);
        check({tag, " hi"}, {16'd0, vec_hi_o}, {16'd0, hi});
        check({tag, " lo"}, {16'd0, vec_lo_o}, {16'd0, hi + 16'd1});
    endtask

    // {req[3:0], mask, exp_take, exp_hi[15:0], exp_ack[3:0]}
    localparam logic [25:0] TBL [8] = '{
        {4'b0001, 1'b0, 1'b1, 16'h3FFA, 4'b0001},
        {4'b0010, 1'b0, 1'b1, 16'h3FF8, 4'b0010},
        {4'b0100, 1'b0, 1'b1, 16'h3FF6, 4'b0100},
        {4'b1000, 1'b0, 1'b1, 16'h3FF4, 4'b1000},
        {4'b0110, 1'b0, 1'b1, 16'h3FF8, 4'b0010},
        {4'b1111, 1'b0, 1'b1, 16'h3FFA, 4'b0001},
        {4'b1111, 1'b1, 1'b0, 16'h0000, 4'b0000},
        {4'b0000, 1'b0, 1'b0, 16'h0000, 4'b0000}
    };

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // block reset state
        repeat (3) @(negedge clk);
        check("R2 idle in reset take", {31'd0, take_o}, 32'd0);
        check("R2 idle in reset hi", {16'd0, vec_hi_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_take("R1 power-up reset", 16'h3FFE);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R7 take one cycle", {31'd0, take_o}, 32'd0);
        check("R8 idle hi zero", {16'd0, vec_hi_o}, 32'd0);

        // table walk
        foreach (TBL[k]) begin
            hw_req_i = TBL[k][25:22];
            mask_i   = TBL[k][21];
            @(negedge clk);
            if (TBL[k][20]) begin
                check_take("R4 table", TBL[k][19:4]);
                check("R9 no ack before done", {28'd0, ack_o}, 32'd0);
                done_i = 1'b1;
                #0.5;
                check("R9 table ack", {28'd0, ack_o}, {28'd0, TBL[k][3:0]});
                hw_req_i = '0;
                @(negedge clk);
                done_i = 1'b0;
                check("R7 table take low", {31'd0, take_o}, 32'd0);
            end else begin
                check("R5 table no take", {31'd0, take_o}, 32'd0);
                hw_req_i = '0;
                mask_i   = 1'b0;
                @(negedge clk);
            end
        end

        // R3: software interrupt with mask set
        mask_i      = 1'b1;
        hw_req_i    = 4'b0001;
        swi_fetch_i = 1'b1;
        @(negedge clk);
        swi_fetch_i = 1'b0;
        check("R3 no take first cycle", {31'd0, take_o}, 32'd0);
        @(negedge clk);
        check_take("R3 swi masked", 16'h3FFC);
        done_i   = 1'b1;
        hw_req_i = '0;
        @(negedge clk);
        done_i = 1'b0;
        mask_i = 1'b0;
        @(negedge clk);

        // R6: snapshot before swi before new request
        hw_req_i    = 4'b0011;
        swi_fetch_i = 1'b1;
        @(negedge clk);
        swi_fetch_i = 1'b0;
        check_take("R6 pending at fetch first", 16'h3FFA);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R8 gap after done", {31'd0, take_o}, 32'd0);
        @(negedge clk);
        check_take("R6 captured before swi", 16'h3FF8);
        done_i   = 1'b1;
        hw_req_i = 4'b0001;
        #0.5;
        check("R9 ack captured", {28'd0, ack_o}, 32'h2);
        @(negedge clk);
        done_i = 1'b0;
        @(negedge clk);
        check_take("R6 swi before new", 16'h3FFC);
        done_i = 1'b1;
        #0.5;
        check("R9 no ack for swi", {28'd0, ack_o}, 32'd0);
        @(negedge clk);
        done_i = 1'b0;
        @(negedge clk);
        check_take("R6 new after swi", 16'h3FFA);
        done_i   = 1'b1;
        hw_req_i = '0;
        @(negedge clk);
        done_i = 1'b0;
        @(negedge clk);

        // R8: hold while done low
        hw_req_i = 4'b0100;
        @(negedge clk);
        check_take("R8 take", 16'h3FF6);
        hw_req_i = 4'b0001;
        repeat (3) @(negedge clk);
        check("R8 held hi", {16'd0, vec_hi_o}, 32'h3FF6);
        check("R8 held lo", {16'd0, vec_lo_o}, 32'h3FF7);
        check("R7 no retake", {31'd0, take_o}, 32'd0);
        done_i   = 1'b1;
        hw_req_i = '0;
        #0.5;
        check("R9 ack held", {28'd0, ack_o}, 32'h4);
        @(negedge clk);
        done_i = 1'b0;
        @(negedge clk);

        // R2/R1: pin reset aborts a held selection
        hw_req_i = 4'b0001;
        @(negedge clk);
        check_take("R4 before abort", 16'h3FFA);
        pin_rst_n = 1'b0;
        hw_req_i  = '0;
        @(negedge clk);
        check("R2 abort take", {31'd0, take_o}, 32'd0);
        check("R2 abort hi", {16'd0, vec_hi_o}, 32'd0);
        done_i = 1'b1;
        #0.5;
        check("R2 no ack in reset", {28'd0, ack_o}, 32'd0);
        done_i    = 1'b0;
        pin_rst_n = 1'b1;
        @(negedge clk);
        check_take("R1 pin reset", 16'h3FFE);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;

        // R2/R1: internal reset discards pending swi
        mask_i      = 1'b1;
        swi_fetch_i = 1'b1;
        @(negedge clk);
        swi_fetch_i = 1'b0;
        int_rst     = 1'b1;
        @(negedge clk);
        int_rst = 1'b0;
        check("R2 int reset no take", {31'd0, take_o}, 32'd0);
        @(negedge clk);
        check_take("R1 internal reset", 16'h3FFE);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 swi discarded", {31'd0, take_o}, 32'd0);
        check("R2 swi discarded hi", {16'd0, vec_hi_o}, 32'd0);
        mask_i = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule